// File: doc/BRIEF.md
# SPI Status Flag Controller

This block is the status and control side of a byte-wide SPI peripheral. A separate shift engine reports three kinds of event to it: a completed received byte, a transmit byte moved into the shifter, and the slave-select level together with the master/slave mode and a transfer-in-progress indication. From these events the block keeps four sticky flags: receive-full, overflow, mode-fault and transmit-empty. It also holds the received byte and three bus-visible registers, and it drives three interrupt requests.

Software clears the flags through access pairs. A status read that observes a flag set arms a clear latch for that flag. The matching follow-up access then clears the flag: a data read for receive-full and overflow, or a control write for mode-fault. When a byte completes while an unread byte is still held, the held byte is kept, the new one is dropped, and overflow is raised. Transmit-empty is cleared by a single write of the data register.

Top module: `spi_flag_ctl`

## Requirements
- R1: After synchronous reset the status register (address 1) reads 0x08, the control register (address 0) reads 0x00, and all interrupts and `rx_hold` are 0.
- R2: Register map: address 0 is control, address 1 is status, address 2 is data, and address 3 reads 0. The status bits are 7 receive-full, 6 error-interrupt-enable, 5 overflow, 4 mode-fault, 3 transmit-empty, 2 mode-fault-enable, and 1:0 rate select. The control bits are 0 receive-interrupt-enable and 1 transmit-interrupt-enable. `bus_rdata` shows the value the register held before the read's clock edge, from the cycle after `bus_rd` until the next read.
- R3: A completed byte that arrives while receive-full is 0 is stored and sets receive-full. `rx_hold` equals receive-full.
- R4: A completed byte that arrives while receive-full is 1, with no clearing data read in the same cycle, sets overflow. The stored byte is left unchanged and the new byte is dropped.
- R5: Receive-full clears only on a data read that follows a status read which saw it set. A data read without such a status read leaves it set.
- R6: Overflow clears on a data read that follows a status read which saw it set.
- R7: With mode-fault-enable at 1, mode-fault sets in slave mode on a rising slave-select edge while a transfer is active, and in master mode in any cycle with slave-select low. With mode-fault-enable at 0, mode-fault never sets.
- R8: Mode-fault clears on a control write that follows a status read which saw it set. A control write without such a read leaves it set.
- R9: Transmit-empty sets when the transmit byte is loaded into the shifter, and clears when the data register is written.
- R10: If a flag is set again after the arming status read and before its follow-up access, the arming is discarded and the flag survives that access.
- R11: When a set event and a completing clear fall in the same cycle, the flag ends up set. A data read that coincides with a new byte returns the old byte and loads the new one without overflow.
- R12: Bus writes never change the four status flags. Writes to status bits 6, 2 and 1:0, and to control bits 1:0, are stored.
- R13: `irq_rx` = receive-full AND receive-interrupt-enable. `irq_tx` = transmit-empty AND transmit-interrupt-enable. `irq_err` = error-interrupt-enable AND (overflow OR mode-fault).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ev_rx_done | input | 1 | Shift engine completed a received byte |
| rx_byte | input | 8 | Byte completed by the shift engine |
| ev_tx_load | input | 1 | Transmit byte moved into the shifter |
| ss_level | input | 1 | Slave-select pin level |
| is_master | input | 1 | 1 = master mode, 0 = slave mode |
| xfer_active | input | 1 | A transfer is in progress |
| bus_rd | input | 1 | Bus read strobe |
| bus_wr | input | 1 | Bus write strobe |
| bus_addr | input | ADDR_W | Register address |
| bus_wdata | input | 8 | Bus write data |
| bus_rdata | output | 8 | Registered read data |
| irq_rx | output | 1 | Receive-full interrupt request |
| irq_tx | output | 1 | Transmit-empty interrupt request |
| irq_err | output | 1 | Overflow / mode-fault interrupt request |
| rx_hold | output | 1 | Receive buffer holds an unread byte |

## Verification
A wrong flag shows up at the ports in the next cycle, through `rx_hold` and the three interrupt lines. Any later status read also exposes it. A wrong clear latch stays hidden until its follow-up access: it then shows as a flag that clears when it should not, or survives when it should clear, on the next status read. A lost or overwritten received byte is visible on the first data read after it. For these reasons the reference model is compared against every output in every cycle, and the directed access pairs cover both the armed and the unarmed case of each latch.

// File: rtl/spi_flag_pkg.sv
package spi_flag_pkg;
  localparam int BYTE_W = 8;
  localparam int RATE_W = 2;

  // status register bit positions (software decodes these)
  localparam int S_RXF   = 7;
  localparam int S_ERRIE = 6;
  localparam int S_OVF   = 5;
  localparam int S_MFLT  = 4;
  localparam int S_TXE   = 3;
  localparam int S_MFEN  = 2;

  // control register bit positions
  localparam int C_RXIE = 0;
  localparam int C_TXIE = 1;

  // flags that use the two-step clear
  localparam int N_CLR = 3;
  localparam int F_RXF = 0;
  localparam int F_OVF = 1;
  localparam int F_MF  = 2;

  typedef struct packed {
    logic rd_ctrl;
    logic rd_stat;
    logic rd_data;
    logic wr_ctrl;
    logic wr_stat;
    logic wr_data;
  } bus_ev_t;
endpackage

// File: rtl/spi_flag_busdec.sv
module spi_flag_busdec
  import spi_flag_pkg::*;
#(
  parameter int ADDR_W    = 2,
  parameter int CTRL_ADDR = 0,
  parameter int STAT_ADDR = 1,
  parameter int DATA_ADDR = 2
) (
  input  logic              bus_rd,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  output bus_ev_t           ev
);
  localparam logic [ADDR_W-1:0] A_CTRL = ADDR_W'(CTRL_ADDR);
  localparam logic [ADDR_W-1:0] A_STAT = ADDR_W'(STAT_ADDR);
  localparam logic [ADDR_W-1:0] A_DATA = ADDR_W'(DATA_ADDR);

  always_comb begin
    ev.rd_ctrl = bus_rd && (bus_addr == A_CTRL);
    ev.rd_stat = bus_rd && (bus_addr == A_STAT);
    ev.rd_data = bus_rd && (bus_addr == A_DATA);
    ev.wr_ctrl = bus_wr && (bus_addr == A_CTRL);
    ev.wr_stat = bus_wr && (bus_addr == A_STAT);
    ev.wr_data = bus_wr && (bus_addr == A_DATA);
  end
endmodule

// File: rtl/spi_flag_cell.sv
module spi_flag_cell #(
  parameter logic RST_VAL = 1'b0
) (
  input  logic clk,
  input  logic rst,
  input  logic set_ev,
  input  logic snoop,
  input  logic consume,
  output logic flag,
  output logic armed
);
  always_ff @(posedge clk) begin
    if (rst) begin
      flag  <= RST_VAL;
      armed <= 1'b0;
    end else if (set_ev) begin
      flag  <= 1'b1;
      armed <= 1'b0;
    end else if (consume) begin
      if (armed) flag <= 1'b0;
      armed <= 1'b0;
    end else if (snoop && flag) begin
      armed <= 1'b1;
    end
  end

  assert_set_wins_R11: assert property (@(posedge clk) disable iff (rst)
    set_ev |=> flag) else $error("set event did not leave flag set");

  assert_no_unarmed_clear_R5: assert property (@(posedge clk) disable iff (rst)
    (flag && !armed) |=> flag) else $error("flag cleared without arming");

  assert_arm_needs_flag_R10: assert property (@(posedge clk) disable iff (rst)
    armed |-> flag) else $error("clear latch armed while flag clear");
endmodule

// File: rtl/spi_flag_rxbuf.sv
module spi_flag_rxbuf
  import spi_flag_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              rx_done,
  input  logic [BYTE_W-1:0] rx_byte,
  input  logic              rxf,
  input  logic              rxf_clearing,
  output logic              accept,
  output logic              ovf_ev,
  output logic [BYTE_W-1:0] rx_data
);
  assign accept = rx_done && (!rxf || rxf_clearing);
  assign ovf_ev = rx_done && !accept;

  always_ff @(posedge clk) begin
    if (rst)         rx_data <= '0;
    else if (accept) rx_data <= rx_byte;
  end

  assert_keep_old_byte_R4: assert property (@(posedge clk) disable iff (rst)
    (rx_done && rxf && !rxf_clearing) |=> $stable(rx_data))
    else $error("held byte overwritten on overflow");

  assert_store_byte_R3: assert property (@(posedge clk) disable iff (rst)
    (rx_done && !rxf) |=> (rx_data == $past(rx_byte)))
    else $error("received byte not stored");
endmodule

// File: rtl/spi_flag_mfdet.sv
module spi_flag_mfdet (
  input  logic clk,
  input  logic rst,
  input  logic mf_en,
  input  logic is_master,
  input  logic ss_level,
  input  logic xfer_active,
  output logic mf_ev
);
  logic ss_q;

  always_ff @(posedge clk) begin
    if (rst) ss_q <= 1'b1;
    else     ss_q <= ss_level;
  end

  always_comb begin
    if (!mf_en)         mf_ev = 1'b0;
    else if (is_master) mf_ev = !ss_level;
    else                mf_ev = xfer_active && ss_level && !ss_q;
  end
endmodule

// File: rtl/spi_flag_ctl.sv
module spi_flag_ctl
  import spi_flag_pkg::*;
#(
  parameter int ADDR_W    = 2,
  parameter int CTRL_ADDR = 0,
  parameter int STAT_ADDR = 1,
  parameter int DATA_ADDR = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              ev_rx_done,
  input  logic [7:0]        rx_byte,
  input  logic              ev_tx_load,
  input  logic              ss_level,
  input  logic              is_master,
  input  logic              xfer_active,
  input  logic              bus_rd,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [7:0]        bus_wdata,
  output logic [7:0]        bus_rdata,
  output logic              irq_rx,
  output logic              irq_tx,
  output logic              irq_err,
  output logic              rx_hold
);
  bus_ev_t             ev;
  logic [N_CLR-1:0]    set_v, cons_v, flag_v, arm_v;
  logic                accept, ovf_ev, mf_ev;
  logic [BYTE_W-1:0]   rx_data, stat_word, ctrl_word, rd_mux;
  logic                txe, errie, mfen, rxie, txie;
  logic [RATE_W-1:0]   rate;
  logic                unused_wdata;

  assign unused_wdata = &{1'b0, bus_wdata[7], bus_wdata[5:3]};

  spi_flag_busdec #(
    .ADDR_W(ADDR_W), .CTRL_ADDR(CTRL_ADDR),
    .STAT_ADDR(STAT_ADDR), .DATA_ADDR(DATA_ADDR)
  ) dec_i (
    .bus_rd(bus_rd), .bus_wr(bus_wr), .bus_addr(bus_addr), .ev(ev)
  );

  spi_flag_rxbuf rxbuf_i (
    .clk(clk), .rst(rst), .rx_done(ev_rx_done), .rx_byte(rx_byte),
    .rxf(flag_v[F_RXF]), .rxf_clearing(arm_v[F_RXF] && ev.rd_data),
    .accept(accept), .ovf_ev(ovf_ev), .rx_data(rx_data)
  );

  spi_flag_mfdet mfdet_i (
    .clk(clk), .rst(rst), .mf_en(mfen), .is_master(is_master),
    .ss_level(ss_level), .xfer_active(xfer_active), .mf_ev(mf_ev)
  );

  assign set_v[F_RXF]  = accept;
  assign set_v[F_OVF]  = ovf_ev;
  assign set_v[F_MF]   = mf_ev;
  assign cons_v[F_RXF] = ev.rd_data;
  assign cons_v[F_OVF] = ev.rd_data;
  assign cons_v[F_MF]  = ev.wr_ctrl;

  for (genvar g = 0; g < N_CLR; g++) begin : g_flag
    spi_flag_cell #(.RST_VAL(1'b0)) cell_i (
      .clk(clk), .rst(rst), .set_ev(set_v[g]), .snoop(ev.rd_stat),
      .consume(cons_v[g]), .flag(flag_v[g]), .armed(arm_v[g])
    );
  end

  // transmit-empty: single-step clear, set wins
  always_ff @(posedge clk) begin
    if (rst)             txe <= 1'b1;
    else if (ev_tx_load) txe <= 1'b1;
    else if (ev.wr_data) txe <= 1'b0;
  end

  // writable configuration bits
  always_ff @(posedge clk) begin
    if (rst) begin
      errie <= 1'b0;
      mfen  <= 1'b0;
      rate  <= '0;
      rxie  <= 1'b0;
      txie  <= 1'b0;
    end else begin
      if (ev.wr_stat) begin
        errie <= bus_wdata[S_ERRIE];
        mfen  <= bus_wdata[S_MFEN];
        rate  <= bus_wdata[RATE_W-1:0];
      end
      if (ev.wr_ctrl) begin
        rxie <= bus_wdata[C_RXIE];
        txie <= bus_wdata[C_TXIE];
      end
    end
  end

  always_comb begin
    stat_word               = '0;
    stat_word[S_RXF]        = flag_v[F_RXF];
    stat_word[S_ERRIE]      = errie;
    stat_word[S_OVF]        = flag_v[F_OVF];
    stat_word[S_MFLT]       = flag_v[F_MF];
    stat_word[S_TXE]        = txe;
    stat_word[S_MFEN]       = mfen;
    stat_word[RATE_W-1:0]   = rate;
    ctrl_word               = '0;
    ctrl_word[C_RXIE]       = rxie;
    ctrl_word[C_TXIE]       = txie;
    if (ev.rd_ctrl)      rd_mux = ctrl_word;
    else if (ev.rd_stat) rd_mux = stat_word;
    else if (ev.rd_data) rd_mux = rx_data;
    else                 rd_mux = '0;
  end

  always_ff @(posedge clk) begin
    if (rst)         bus_rdata <= '0;
    else if (bus_rd) bus_rdata <= rd_mux;
  end

  assign irq_rx  = flag_v[F_RXF] && rxie;
  assign irq_tx  = txe && txie;
  assign irq_err = errie && (flag_v[F_OVF] || flag_v[F_MF]);
  assign rx_hold = flag_v[F_RXF];

  assert_tx_load_sets_R9: assert property (@(posedge clk) disable iff (rst)
    ev_tx_load |=> irq_tx || !txie) else $error("transmit-empty not set");

  assert_mf_gated_R7: assert property (@(posedge clk) disable iff (rst)
    (!mfen && !flag_v[F_MF]) |=> !flag_v[F_MF]) else $error("mode-fault set while disabled");

  assert_write_no_flag_R12: assert property (@(posedge clk) disable iff (rst)
    (bus_wr && !ev_rx_done && !rx_hold) |=> !rx_hold) else $error("bus write set receive-full");

  assert_ovf_hold_R4: assert property (@(posedge clk) disable iff (rst)
    ovf_ev |=> flag_v[F_OVF] && rx_hold) else $error("overflow not flagged");
endmodule

// File: tb/spi_flag_ctl_tb.sv
module spi_flag_ctl_tb_top;
  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       ev_rx_done = 0, ev_tx_load = 0, ss_level = 1, is_master = 0, xfer_active = 0;
  logic       bus_rd = 0, bus_wr = 0;
  logic [1:0] bus_addr = '0;
  logic [7:0] rx_byte = '0, bus_wdata = '0, bus_rdata;
  logic       irq_rx, irq_tx, irq_err, rx_hold;

  int  n_checks = 0, n_errors = 0;
  bit  done = 0, run = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  spi_flag_ctl dut_i (
    .clk(clk), .rst(rst), .ev_rx_done(ev_rx_done), .rx_byte(rx_byte),
    .ev_tx_load(ev_tx_load), .ss_level(ss_level), .is_master(is_master),
    .xfer_active(xfer_active), .bus_rd(bus_rd), .bus_wr(bus_wr),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .irq_rx(irq_rx), .irq_tx(irq_tx), .irq_err(irq_err), .rx_hold(rx_hold)
  );

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_errors++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  // behavioural reference model
  bit m_rxf, m_ovf, m_mf, m_txe, m_arx, m_aov, m_amf;
  bit m_errie, m_mfen, m_rxie, m_txie, m_ssq;
  bit [1:0] m_rate;
  bit [7:0] m_rxd, m_rdata;

  function automatic bit [1:0] step(bit f, bit a, bit s, bit n, bit c);
    if (s)           return 2'b10;
    if (c)           return {f && !a, 1'b0};
    if (n && f)      return 2'b11;
    return {f, a};
  endfunction

  always @(posedge clk) begin : ref_model
    bit rs, rdd, wc, ws, wd, crx, acc, oev, mev;
    if (rst) begin
      {m_rxf, m_ovf, m_mf, m_arx, m_aov, m_amf} = '0;
      m_txe = 1; m_ssq = 1;
      {m_errie, m_mfen, m_rxie, m_txie} = '0;
      m_rate = 0; m_rxd = 0; m_rdata = 0;
    end else begin
      rs  = bus_rd && bus_addr == 1;
      rdd = bus_rd && bus_addr == 2;
      wc  = bus_wr && bus_addr == 0;
      ws  = bus_wr && bus_addr == 1;
      wd  = bus_wr && bus_addr == 2;
      if (bus_rd)
        case (bus_addr)
          0: m_rdata = {6'b0, m_txie, m_rxie};
          1: m_rdata = {m_rxf, m_errie, m_ovf, m_mf, m_txe, m_mfen, m_rate};
          2: m_rdata = m_rxd;
          default: m_rdata = 0;
        endcase
      crx = m_arx && rdd;
      acc = ev_rx_done && (!m_rxf || crx);
      oev = ev_rx_done && !acc;
      mev = m_mfen && (is_master ? !ss_level : (xfer_active && ss_level && !m_ssq));
      if (acc) m_rxd = rx_byte;
      {m_rxf, m_arx} = step(m_rxf, m_arx, acc, rs, rdd);
      {m_ovf, m_aov} = step(m_ovf, m_aov, oev, rs, rdd);
      {m_mf,  m_amf} = step(m_mf,  m_amf, mev, rs, wc);
      if (ev_tx_load) m_txe = 1; else if (wd) m_txe = 0;
      if (wc) begin m_rxie = bus_wdata[0]; m_txie = bus_wdata[1]; end
      if (ws) begin m_errie = bus_wdata[6]; m_mfen = bus_wdata[2]; m_rate = bus_wdata[1:0]; end
      m_ssq = ss_level;
    end
  end

  always @(negedge clk) begin
    if (run && !rst) begin
      check("R2 model rdata", bus_rdata, m_rdata);
      check("R3 model rx_hold", rx_hold, m_rxf);
      check("R13 model irq_rx", irq_rx, m_rxf && m_rxie);
      check("R13 model irq_tx", irq_tx, m_txe && m_txie);
      check("R13 model irq_err", irq_err, m_errie && (m_ovf || m_mf));
    end
  end

  task automatic tick(); @(posedge clk); @(negedge clk); endtask

  task automatic rd(input logic [1:0] a, output logic [7:0] d);
    bus_rd = 1; bus_addr = a; tick(); bus_rd = 0; d = bus_rdata;
  endtask

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    bus_wr = 1; bus_addr = a; bus_wdata = d; tick(); bus_wr = 0;
  endtask

  task automatic rx(input logic [7:0] b);
    ev_rx_done = 1; rx_byte = b; tick(); ev_rx_done = 0;
  endtask

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      n_errors++;
      $display("FAIL watchdog expired");
      $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
      $finish;
    end
  end

  initial begin
    logic [7:0] d;
    repeat (3) @(negedge clk);
    rst = 0; run = 1;
    check("R1 irq/hold", {irq_rx, irq_tx, irq_err, rx_hold}, 0);
    rd(1, d); check("R1 status reset", d, 8'h08);
    rd(0, d); check("R1 control reset", d, 8'h00);
    rd(3, d); check("R2 unused addr", d, 8'h00);
    // writable bits
    wr(1, 8'hFF); rd(1, d); check("R12 status write", d, 8'h4F);
    wr(0, 8'h03); rd(0, d); check("R12 control write", d, 8'h03);
    check("R13 irq_tx", irq_tx, 1);
    // transmit-empty
    wr(2, 8'h00); rd(1, d); check("R9 txe cleared", d, 8'h47);
    check("R13 irq_tx low", irq_tx, 0);
    ev_tx_load = 1; tick(); ev_tx_load = 0;
    rd(1, d); check("R9 txe set", d, 8'h4F);
    // receive
    rx(8'hA5);
    check("R3 rx_hold", rx_hold, 1);
    check("R13 irq_rx", irq_rx, 1);
    rd(2, d); check("R3 data", d, 8'hA5);
    rd(1, d); check("R5 unarmed read keeps rxf", d, 8'hCF);
    rd(2, d); rd(1, d); check("R5 rxf cleared", d, 8'h4F);
    // overflow
    rx(8'h11); rx(8'h22);
    rd(1, d); check("R4 overflow status", d, 8'hEF);
    check("R13 irq_err", irq_err, 1);
    rd(2, d); check("R4 old byte kept", d, 8'h11);
    rd(1, d); check("R6 overflow cleared", d, 8'h4F);
    // latch discarded by a new set
    rx(8'h33); rx(8'h44);
    rd(1, d); check("R10 setup", d, 8'hEF);
    rx(8'h55);
    rd(2, d); check("R10 data", d, 8'h33);
    rd(1, d); check("R10 ovf survives", d, 8'h6F);
    rd(2, d); rd(1, d); check("R6 second clear", d, 8'h4F);
    // same-cycle set and clear
    rx(8'h66);
    rd(1, d); check("R11 setup", d, 8'hCF);
    bus_rd = 1; bus_addr = 2; ev_rx_done = 1; rx_byte = 8'h77; tick();
    bus_rd = 0; ev_rx_done = 0;
    check("R11 old byte returned", bus_rdata, 8'h66);
    rd(1, d); check("R11 rxf stays, no ovf", d, 8'hCF);
    rd(2, d); check("R11 new byte stored", d, 8'h77);
    rd(1, d); check("R11 cleanup", d, 8'h4F);
    ev_tx_load = 1; bus_wr = 1; bus_addr = 2; tick(); ev_tx_load = 0; bus_wr = 0;
    rd(1, d); check("R11 txe set wins", d, 8'h4F);
    // mode fault, slave
    ss_level = 1; xfer_active = 0; tick(); ss_level = 0; tick(); ss_level = 1; tick();
    rd(1, d); check("R7 no fault idle", d, 8'h4F);
    xfer_active = 1; ss_level = 0; tick(); ss_level = 1; tick(); xfer_active = 0;
    wr(0, 8'h03);
    rd(1, d); check("R8 unarmed ctrl write", d, 8'h5F);
    check("R13 irq_err mf", irq_err, 1);
    wr(0, 8'h03); rd(1, d); check("R8 mode-fault cleared", d, 8'h4F);
    // mode fault, master
    is_master = 1; tick(); ss_level = 0; tick(); ss_level = 1;
    rd(1, d); check("R7 master fault", d, 8'h5F);
    wr(0, 8'h03); rd(1, d); check("R8 master clear", d, 8'h4F);
    wr(1, 8'h40); rd(1, d); check("R12 mfen off", d, 8'h48);
    ss_level = 0; tick(); tick(); ss_level = 1; tick();
    rd(1, d); check("R7 disabled", d, 8'h48);
    is_master = 0; tick();
    // writes leave flags alone
    rx(8'h88); wr(1, 8'h00);
    rd(1, d); check("R12 flags ignore write", d, 8'h88);
    wr(1, 8'hB4); rd(1, d); check("R12 flags ignore write 2", d, 8'h8C);
    tick(); tick();
    done = 1;
    $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
    $finish;
  end
endmodule